// File: doc/BRIEF.md
# Character LCD Startup and Message Sequencer

This block runs a fixed script that brings a 16x2 character LCD controller out of power-up and then writes a four-letter word at a chosen screen position. Every script entry is an 8-bit value tagged as either a controller command or a display character. Entries go out one at a time to a separate bus-cycle engine over a valid/acknowledge handshake. The engine drives the LCD pins. This block never touches them.

A start pulse launches the script, and a mode input sampled with that pulse picks the pacing. In fixed-delay mode, a programmable wait follows every acknowledged entry. In busy-flag mode, a single power-up wait comes before the first entry, and after that entries are offered back to back, because the engine polls the controller's busy flag itself. When the script ends, the block raises done and stays idle until reset.

Top module: `lcd_script_seq`

## Requirements
- R1: After reset, req_valid_o and done_o are 0, and no entry is offered until a start pulse is sampled.
- R2: Entries are offered in this order: 0x38, 0x0E, 0x01, 0x06, then the address command 0x80 | (ROW*0x40 + COL), which is 0x84 by default, then 0x46, 0x69, 0x6E, 0x65 ("Fine").
- R3: req_is_data_o is 0 for the five command entries and 1 for the four character entries.
- R4: Once req_valid_o is high, it stays high and req_data_o and req_is_data_o stay unchanged until the cycle in which req_ack_i is sampled high.
- R5: In fixed-delay mode (mode_busy_i = 0 at start), the first entry is offered the cycle after start is sampled. After every acknowledge, including the last, req_valid_o is low for exactly ENTRY_WAIT cycles.
- R6: In busy-flag mode (mode_busy_i = 1 at start), req_valid_o stays low for exactly POWERUP_WAIT cycles after start. After that, each acknowledge except the last is followed at once by the next entry, with no low cycle.
- R7: done_o rises once the script ends: ENTRY_WAIT cycles after the final acknowledge in fixed-delay mode, and the cycle after it in busy-flag mode. done_o then stays high with req_valid_o low, and start is ignored until reset.
- R8: The mode is captured with start. Changes on mode_busy_i during a run do not alter the pacing.
- R9: A start pulse during a run does not restart or disturb the script.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that launches the script from idle |
| mode_busy_i | input | 1 | 1 = busy-flag pacing, 0 = fixed-delay pacing; sampled with start |
| req_valid_o | output | 1 | Entry offered to the bus engine |
| req_data_o | output | 8 | Command or character value |
| req_is_data_o | output | 1 | 0 = command (register select low), 1 = character (register select high) |
| req_ack_i | input | 1 | Engine accepts the offered entry |
| done_o | output | 1 | Script finished; held until reset |

## Verification
The collision that matters is an acknowledge landing in the same cycle as a fresh start pulse and a flip of the mode input. In both pacing modes, the bench raises start and inverts mode_busy_i exactly on the acknowledge edge of a mid-script entry. It then checks that the remaining entries keep their order, flags and gap lengths as if nothing had happened. A second collision is the final acknowledge meeting the end of the script. The bench counts the low cycles from that acknowledge until done_o rises, and requires the count to match the pacing captured at start.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

   localparam int SCRIPT_LEN = 9;

   typedef struct packed {
      logic       is_data;
      logic [7:0] code;
   } lcd_entry_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PWR_WAIT,
      ST_OFFER,
      ST_GAP,
      ST_DONE
   } seq_state_t;

   // Script contents: startup commands, cursor address, then the word.
   function automatic lcd_entry_t script_entry(input int idx, input logic [7:0] addr_cmd);
      lcd_entry_t e;
      case (idx)
         0:       e = '{is_data: 1'b0, code: 8'h38};
         1:       e = '{is_data: 1'b0, code: 8'h0E};
         2:       e = '{is_data: 1'b0, code: 8'h01};
         3:       e = '{is_data: 1'b0, code: 8'h06};
         4:       e = '{is_data: 1'b0, code: addr_cmd};
         5:       e = '{is_data: 1'b1, code: 8'h46};
         6:       e = '{is_data: 1'b1, code: 8'h69};
         7:       e = '{is_data: 1'b1, code: 8'h6E};
         default: e = '{is_data: 1'b1, code: 8'h65};
      endcase
      return e;
   endfunction

endpackage

// File: rtl/lcd_script_rom.sv
module lcd_script_rom
   import lcd_seq_pkg::*;
#(
   parameter int ROW   = 0,
   parameter int COL   = 4,
   parameter int IDX_W = 4
) (
   input  logic [IDX_W-1:0] idx_i,
   output lcd_entry_t       entry_o
);

   localparam int         LINE_OFS = 64;
   localparam logic [7:0] ADDR_CMD = 8'h80 | 8'(ROW * LINE_OFS + COL);

   if (ROW < 0 || ROW > 1) begin : g_bad_row
      $error("lcd_script_rom: ROW must be 0 or 1");
   end
   if (COL < 0 || COL > 15) begin : g_bad_col
      $error("lcd_script_rom: COL must be 0..15");
   end

   lcd_entry_t table_q [SCRIPT_LEN];

   for (genvar g = 0; g < SCRIPT_LEN; g++) begin : g_tab
      assign table_q[g] = script_entry(g, ADDR_CMD);
   end

   always_comb begin
      entry_o = table_q[SCRIPT_LEN-1];
      for (int i = 0; i < SCRIPT_LEN; i++) begin
         if (idx_i == IDX_W'(i)) entry_o = table_q[i];
      end
   end

endmodule

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             run_i,
   output logic             expired_o
);

   if (CNT_W < 1) begin : g_bad_w
      $error("lcd_wait_timer: CNT_W must be positive");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (run_i && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/lcd_script_seq.sv
module lcd_script_seq
   import lcd_seq_pkg::*;
#(
   parameter int ROW          = 0,
   parameter int COL          = 4,
   parameter int ENTRY_WAIT   = 200000,
   parameter int POWERUP_WAIT = 4000000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       mode_busy_i,
   output logic       req_valid_o,
   output logic [7:0] req_data_o,
   output logic       req_is_data_o,
   input  logic       req_ack_i,
   output logic       done_o
);

   localparam int IDX_W    = $clog2(SCRIPT_LEN);
   localparam int MAX_WAIT = (ENTRY_WAIT > POWERUP_WAIT) ? ENTRY_WAIT : POWERUP_WAIT;
   localparam int CNT_W    = $clog2(MAX_WAIT + 1);

   if (ENTRY_WAIT < 1) begin : g_bad_entry
      $error("lcd_script_seq: ENTRY_WAIT must be at least 1");
   end
   if (POWERUP_WAIT < 1) begin : g_bad_pwr
      $error("lcd_script_seq: POWERUP_WAIT must be at least 1");
   end

   seq_state_t       state_q;
   logic [IDX_W-1:0] idx_q;
   logic             mode_q;
   logic             last_entry;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_run;
   logic             tmr_expired;
   lcd_entry_t       cur_entry;

   assign last_entry = (idx_q == IDX_W'(SCRIPT_LEN - 1));

   lcd_script_rom #(
      .ROW   (ROW),
      .COL   (COL),
      .IDX_W (IDX_W)
   ) u_rom (
      .idx_i   (idx_q),
      .entry_o (cur_entry)
   );

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (state_q == ST_IDLE && start_i && mode_busy_i) begin
         tmr_load = 1'b1;
         tmr_val  = CNT_W'(POWERUP_WAIT - 1);
      end else if (state_q == ST_OFFER && req_ack_i && !mode_q) begin
         tmr_load = 1'b1;
         tmr_val  = CNT_W'(ENTRY_WAIT - 1);
      end
   end

   assign tmr_run = (state_q == ST_PWR_WAIT) || (state_q == ST_GAP);

   lcd_wait_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .run_i      (tmr_run),
      .expired_o  (tmr_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         mode_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  mode_q  <= mode_busy_i;
                  idx_q   <= '0;
                  state_q <= mode_busy_i ? ST_PWR_WAIT : ST_OFFER;
               end
            end
            ST_PWR_WAIT: begin
               if (tmr_expired) state_q <= ST_OFFER;
            end
            ST_OFFER: begin
               if (req_ack_i) begin
                  if (!mode_q)         state_q <= ST_GAP;
                  else if (last_entry) state_q <= ST_DONE;
                  else                 idx_q   <= idx_q + 1'b1;
               end
            end
            ST_GAP: begin
               if (tmr_expired) begin
                  if (last_entry) begin
                     state_q <= ST_DONE;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= ST_OFFER;
                  end
               end
            end
            ST_DONE: state_q <= ST_DONE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_valid_o   = (state_q == ST_OFFER);
   assign req_data_o    = cur_entry.code;
   assign req_is_data_o = cur_entry.is_data;
   assign done_o        = (state_q == ST_DONE);

endmodule

// File: rtl/lcd_script_seq_chk.sv
module lcd_script_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [7:0] req_data,
   input logic       req_is_data,
   input logic       req_ack,
   input logic       done,
   input logic       mode_q,
   input logic       last_entry
);

   p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ack |=> req_valid && $stable(req_data) && $stable(req_is_data));

   p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   p_quiet_when_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_valid);

   p_fixed_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ack && !mode_q |=> !req_valid);

   p_busy_back_to_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ack && mode_q && !last_entry |=> req_valid);

   p_cmd_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_data[7] |-> !req_is_data);

endmodule

bind lcd_script_seq lcd_script_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid_o),
   .req_data    (req_data_o),
   .req_is_data (req_is_data_o),
   .req_ack     (req_ack_i),
   .done        (done_o),
   .mode_q      (mode_q),
   .last_entry  (last_entry)
);

// File: tb/lcd_script_seq_tb.sv
`timescale 1ns/1ps
module lcd_script_seq_tb;

   localparam int EW = 5;
   localparam int PW = 7;
   localparam int N  = 9;

   // {hold cycles[3:0], is_data, code[7:0]}
   localparam logic [12:0] VEC [N] = '{
      {4'd0, 1'b0, 8'h38}, {4'd2, 1'b0, 8'h0E}, {4'd0, 1'b0, 8'h01},
      {4'd3, 1'b0, 8'h06}, {4'd1, 1'b0, 8'h84}, {4'd0, 1'b1, 8'h46},
      {4'd2, 1'b1, 8'h69}, {4'd0, 1'b1, 8'h6E}, {4'd1, 1'b1, 8'h65}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       mode_busy_i = 1'b0;
   logic       req_ack_i = 1'b0;
   logic       req_valid_o;
   logic [7:0] req_data_o;
   logic       req_is_data_o;
   logic       done_o;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   lcd_script_seq #(
      .ROW(0), .COL(4), .ENTRY_WAIT(EW), .POWERUP_WAIT(PW)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_busy_i(mode_busy_i),
      .req_valid_o(req_valid_o), .req_data_o(req_data_o), .req_is_data_o(req_is_data_o),
      .req_ack_i(req_ack_i), .done_o(done_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; start_i = 1'b0; req_ack_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_start(input bit mode);
      mode_busy_i = mode; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // Count low cycles until valid, then check entry, hold, and acknowledge.
   task automatic serve(input int i, input int exp_gap, input bit collide);
      int gap = 0;
      while (!req_valid_o) begin gap++; @(negedge clk); end
      check(gap == exp_gap, (exp_gap == PW) ? "R6 powerup gap" :
            (exp_gap == EW) ? "R5 fixed gap" : "R5/R6 gap", gap, exp_gap);
      check(req_data_o == VEC[i][7:0], "R2 order", req_data_o, VEC[i][7:0]);
      check(req_is_data_o == VEC[i][8], "R3 flag", req_is_data_o, VEC[i][8]);
      for (int h = 0; h < int'(VEC[i][12:9]); h++) begin
         @(negedge clk);
         check(req_valid_o && req_data_o == VEC[i][7:0], "R4 hold", req_data_o, VEC[i][7:0]);
      end
      req_ack_i = 1'b1;
      if (collide) begin start_i = 1'b1; mode_busy_i = ~mode_busy_i; end  // R8 R9
      @(negedge clk);
      req_ack_i = 1'b0; start_i = 1'b0;
   endtask

   task automatic run_script(input bit mode);
      int g = 0;
      pulse_start(mode);
      for (int i = 0; i < N; i++)
         serve(i, (i == 0) ? (mode ? PW : 0) : (mode ? 0 : EW), i == 3);
      while (!done_o) begin g++; @(negedge clk); end
      check(g == (mode ? 0 : EW), "R7 done timing", g, mode ? 0 : EW);
      check(!req_valid_o, "R7 valid low when done", req_valid_o, 0);
      pulse_start(mode);
      repeat (6) @(negedge clk);
      check(done_o && !req_valid_o, "R7 start ignored after done", req_valid_o, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset();
      check(!req_valid_o && !done_o, "R1 reset state", {req_valid_o, done_o}, 0);
      repeat (5) @(negedge clk);
      check(!req_valid_o, "R1 no entry without start", req_valid_o, 0);

      run_script(1'b0);   // fixed-delay pacing, R5 R8 R9 collisions at entry 3
      do_reset();
      run_script(1'b1);   // busy-flag pacing, R6

      // Reset mid-run returns to idle, and the next run starts from the top.
      do_reset();
      pulse_start(1'b0);
      serve(0, 0, 1'b0);
      serve(1, EW, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      check(!req_valid_o && !done_o, "R1 reset mid-run", req_valid_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      pulse_start(1'b0);
      check(req_valid_o && req_data_o == 8'h38, "R2 restart first entry", req_data_o, 8'h38);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule